// File: doc/BRIEF.md
# Flash program/erase status flag generator

This block is a synthesizable behavioural model of the status that a parallel NOR flash puts on its read data bus while an internal program or erase is running. It sits behind a chip-enable, output-enable and write-enable strobe interface. It decodes the unlock/command write sequences, and it keeps a small word array so that program and erase have real effects. A busy timer sets how long each operation lasts.

While the model is busy, every read returns a status byte and not array data, whatever the address. Bit 7 is the polling bit: it is the complement of the programmed bit during a program and 0 during an erase. Bit 6 inverts on every new read access. Bit 5 reports a program that could not complete. Bits 4 to 0 read 0. Programs to protected sectors and erases in which every selected sector is protected run for a short fixed time and then leave the array unchanged.

The strobes are plain active-low control pins sampled on `clk`. There is no valid/ready stream. A write is taken on the clock edge where `we_n` is first seen high again while `ce_n` is low, using the `addr` and `wdata` present at that edge. A read access begins on the edge where `ce_n` and `oe_n` are first both seen low. `rdata` shows the result from that edge until the edge where the access is seen to end. Durations are set in microseconds and multiplied by `CLK_MHZ`. With the defaults, a program takes 40 cycles, an erase 200, the sector-select window 16, a protected program 8 and an all-protected erase 3200.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is in read mode, the toggle bit is cleared, and the word at address i reads ((i*29) mod 256) XOR C3h.
- R2: The writes AAh@2Ah, 55h@15h, A0h@2Ah and then D@A start a program. It is busy for PROG_US*CLK_MHZ cycles after the edge that takes the fourth write. The word at A then becomes old AND D.
- R3: While a program is busy, any read returns bit 7 equal to NOT D[7], bit 5 equal to 0 and bits 4..0 equal to 0. After completion, a read of A returns the stored word.
- R4: The writes AAh@2Ah, 55h@15h, 80h@2Ah, AAh@2Ah, 55h@15h and 10h@2Ah start a chip erase. While it is busy, reads return bit 7 = 0. Afterwards every word in an unprotected sector reads FFh, and protected sectors (PROT_MASK bit s for sector s = addr[5:4]) keep their contents.
- R5: While busy, bit 6 inverts at the start of every read access, and the first access after an operation starts reads bit 6 = 1. Once the block is back in read mode, successive reads return identical array data.
- R6: A program into a protected sector shows busy status for exactly PROT_PROG_US*CLK_MHZ cycles and leaves the word unchanged.
- R7: Five erase-setup writes followed by 30h at any address of a sector open a select window of SE_TMO_US*CLK_MHZ cycles. During the window a further 30h write adds that sector and restarts the window. Reads in the window return bit 7 = 0 with bit 6 toggling. When the window ends, only the selected unprotected sectors are erased.
- R8: An erase in which every selected sector is protected stays busy for PROT_ERASE_US*CLK_MHZ cycles after the window, then returns to read mode with the array unchanged.
- R9: A program with a 1 in D where the stored word holds a 0 runs for the program time and then fails. From then on reads return bit 5 = 1, bit 7 = NOT D[7] and a toggling bit 6, and all writes are ignored until reset.
- R10: Reset during any operation, including the failed state, aborts it and returns the block to read mode with the array reinitialised.
- R11: A write that does not match the next step of a command sequence returns the decoder to its start, and the following writes do not start an operation.
- R12: When ce_n or oe_n is high, rdata is 00h. Status is returned for reads at any address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; aborts any operation |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable; write taken on its rising edge |
| addr | input | ADDR_W | Word address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or status byte |

## Verification
The hardest situations to reach are the failed state and the all-protected erase. The failed state needs a word first programmed down to zeros and then a program asking for a 1 in that word. The all-protected erase needs a sector erase aimed only at the protected top sector, followed by a wait of over three thousand cycles. The bench sets up both in sequence, and it re-opens the select window with a second sector write within the 16-cycle window. Reads are placed at exact cycle offsets from the commit edge, so the toggle phase and the protected-program length are checked to the cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    ST_READY,
    ST_PROG,
    ST_SEWAIT,
    ST_ERASE,
    ST_FAIL
  } op_st_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_PROG,
    CMD_CHIP,
    CMD_SECT
  } cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_U1,
    SQ_U2,
    SQ_PSET,
    SQ_E1,
    SQ_E2,
    SQ_E3
  } seq_e;

  localparam logic [7:0] K_UNLK1   = 8'hAA;
  localparam logic [7:0] K_UNLK2   = 8'h55;
  localparam logic [7:0] K_PROG    = 8'hA0;
  localparam logic [7:0] K_ERSETUP = 8'h80;
  localparam logic [7:0] K_CHIP    = 8'h10;
  localparam logic [7:0] K_SECT    = 8'h30;

  function automatic logic [7:0] init_byte(int i);
    return 8'(i * 29) ^ 8'hC3;
  endfunction

endpackage

// File: rtl/fsg_cmd_decode.sv
module fsg_cmd_decode
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 6'h2A,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 6'h15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_window,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output cmd_e              cmd
);

  seq_e sq, sq_nxt;
  logic at_a, at_b;

  assign at_a = (wr_addr == UNLOCK_A);
  assign at_b = (wr_addr == UNLOCK_B);

  always_comb begin
    cmd    = CMD_NONE;
    sq_nxt = sq;
    if (!en) begin
      sq_nxt = SQ_IDLE;
    end else if (in_window) begin
      sq_nxt = SQ_IDLE;
      if (wr_stb && wr_data == K_SECT) cmd = CMD_SECT;
    end else if (wr_stb) begin
      sq_nxt = SQ_IDLE;
      case (sq)
        SQ_IDLE: if (at_a && wr_data == K_UNLK1) sq_nxt = SQ_U1;
        SQ_U1:   if (at_b && wr_data == K_UNLK2) sq_nxt = SQ_U2;
        SQ_U2: begin
          if (at_a && wr_data == K_PROG) sq_nxt = SQ_PSET;
          else if (at_a && wr_data == K_ERSETUP) sq_nxt = SQ_E1;
        end
        SQ_PSET: cmd = CMD_PROG;
        SQ_E1:   if (at_a && wr_data == K_UNLK1) sq_nxt = SQ_E2;
        SQ_E2:   if (at_b && wr_data == K_UNLK2) sq_nxt = SQ_E3;
        SQ_E3: begin
          if (at_a && wr_data == K_CHIP) cmd = CMD_CHIP;
          else if (wr_data == K_SECT) cmd = CMD_SECT;
        end
        default: sq_nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= SQ_IDLE;
    else        sq <= sq_nxt;
  end

endmodule

// File: rtl/fsg_timer.sv
module fsg_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;
  logic             run;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      run <= 1'b1;
    end else if (expire) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2: a running count steps down by one each cycle
  p_cnt_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/fsg_status.sv
module fsg_status
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_start,
  input  logic       rd_act,
  input  op_st_e     st,
  input  logic       pd7,
  input  logic [7:0] arr_q,
  output logic [7:0] rdata
);

  logic tog;
  logic busy;

  assign busy = (st != ST_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tog <= 1'b0;
    else if (!busy)    tog <= 1'b0;
    else if (rd_start) tog <= ~tog;
  end

  always_comb begin
    rdata = '0;
    if (rd_act) begin
      case (st)
        ST_READY:            rdata = arr_q;
        ST_PROG:             rdata = {~pd7, tog, 6'b0};
        ST_FAIL:             rdata = {~pd7, tog, 1'b1, 5'b0};
        ST_SEWAIT, ST_ERASE: rdata = {1'b0, tog, 6'b0};
        default:             rdata = arr_q;
      endcase
    end
  end

  // R5: each new read access during busy flips the toggle bit
  p_tog_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_start) |=> (tog != $past(tog)));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 4'b1000,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 6'h2A,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 6'h15,
  parameter int CLK_MHZ = 8,
  parameter int PROG_US = 5,
  parameter int ERASE_US = 25,
  parameter int SE_TMO_US = 2,
  parameter int PROT_PROG_US = 1,
  parameter int PROT_ERASE_US = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SECT_N = 1 << SECT_W;
  localparam int WORD_W = ADDR_W - SECT_W;
  localparam int PG_CYC = PROG_US * CLK_MHZ;
  localparam int ER_CYC = ERASE_US * CLK_MHZ;
  localparam int SE_CYC = SE_TMO_US * CLK_MHZ;
  localparam int PP_CYC = PROT_PROG_US * CLK_MHZ;
  localparam int PE_CYC = PROT_ERASE_US * CLK_MHZ;
  localparam int CNT_W  = $clog2(PG_CYC + ER_CYC + SE_CYC + PP_CYC + PE_CYC + 1);

  op_st_e st;
  cmd_e   cmd;
  logic   we_q, rd_q, wr_stb, rd_raw, rd_start;
  logic [ADDR_W-1:0] addr_q, op_addr;
  logic [7:0]        op_data;
  logic [7:0]        mem [DEPTH];
  logic [SECT_N-1:0] sel, clr, addr_hot;
  logic [SECT_W-1:0] addr_sect, op_sect;
  logic              prot_only, prog_bad, prog_commit, erase_done;
  logic              t_load, t_expire;
  logic [CNT_W-1:0]  t_val;
  logic              word_clr [DEPTH];

  assign rd_raw    = !ce_n && !oe_n;
  assign rd_start  = rd_raw && !rd_q;
  assign wr_stb    = we_n && !we_q && !ce_n;
  assign addr_sect = addr[ADDR_W-1 -: SECT_W];
  assign op_sect   = op_addr[ADDR_W-1 -: SECT_W];
  assign addr_hot  = SECT_N'(1) << addr_sect;
  assign clr       = sel & ~PROT_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b1;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      we_q   <= we_n;
      rd_q   <= rd_raw;
      addr_q <= addr;
    end
  end

  fsg_cmd_decode #(
    .ADDR_W  (ADDR_W),
    .UNLOCK_A(UNLOCK_A),
    .UNLOCK_B(UNLOCK_B)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (st == ST_READY || st == ST_SEWAIT),
    .in_window(st == ST_SEWAIT),
    .wr_stb   (wr_stb),
    .wr_addr  (addr),
    .wr_data  (wdata),
    .cmd      (cmd)
  );

  // timer load selection
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    case (st)
      ST_READY: begin
        if (cmd == CMD_PROG) begin
          t_load = 1'b1;
          t_val  = PROT_MASK[addr_sect] ? CNT_W'(PP_CYC - 1) : CNT_W'(PG_CYC - 1);
        end else if (cmd == CMD_CHIP) begin
          t_load = 1'b1;
          t_val  = (|(~PROT_MASK)) ? CNT_W'(ER_CYC - 1) : CNT_W'(PE_CYC - 1);
        end else if (cmd == CMD_SECT) begin
          t_load = 1'b1;
          t_val  = CNT_W'(SE_CYC - 1);
        end
      end
      ST_SEWAIT: begin
        if (cmd == CMD_SECT) begin
          t_load = 1'b1;
          t_val  = CNT_W'(SE_CYC - 1);
        end else if (t_expire) begin
          t_load = 1'b1;
          t_val  = (|clr) ? CNT_W'(ER_CYC - 1) : CNT_W'(PE_CYC - 1);
        end
      end
      default: ;
    endcase
  end

  fsg_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .load_val(t_val),
    .expire  (t_expire)
  );

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_wclr
      assign word_clr[g] = clr[SECT_W'(g >> WORD_W)];
    end
  endgenerate

  assign prog_commit = (st == ST_PROG) && t_expire && !prot_only && !prog_bad;
  assign erase_done  = (st == ST_ERASE) && t_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_READY;
      sel       <= '0;
      op_addr   <= '0;
      op_data   <= '0;
      prot_only <= 1'b0;
      prog_bad  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
    end else begin
      case (st)
        ST_READY: begin
          case (cmd)
            CMD_PROG: begin
              op_addr   <= addr;
              op_data   <= wdata;
              prot_only <= PROT_MASK[addr_sect];
              prog_bad  <= ((mem[addr] & wdata) != wdata);
              st        <= ST_PROG;
            end
            CMD_CHIP: begin
              sel <= '1;
              st  <= ST_ERASE;
            end
            CMD_SECT: begin
              sel <= addr_hot;
              st  <= ST_SEWAIT;
            end
            default: ;
          endcase
        end
        ST_SEWAIT: begin
          if (cmd == CMD_SECT) sel <= sel | addr_hot;
          else if (t_expire)   st  <= ST_ERASE;
        end
        ST_ERASE: begin
          if (erase_done) begin
            for (int i = 0; i < DEPTH; i++)
              if (word_clr[i]) mem[i] <= 8'hFF;
            st <= ST_READY;
          end
        end
        ST_PROG: begin
          if (t_expire) begin
            if (prog_commit) mem[op_addr] <= mem[op_addr] & op_data;
            st <= (!prot_only && prog_bad) ? ST_FAIL : ST_READY;
          end
        end
        ST_FAIL: ;
        default: st <= ST_READY;
      endcase
    end
  end

  fsg_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_start(rd_start),
    .rd_act  (rd_q),
    .st      (st),
    .pd7     (op_data[7]),
    .arr_q   (mem[addr_q]),
    .rdata   (rdata)
  );

  // R9: the failed state is left only through reset
  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAIL) |=> (st == ST_FAIL));

  // R6: no word in a protected sector is ever programmed
  p_prot_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_commit |-> !PROT_MASK[op_sect]);

  // R11: the decoder issues commands only when the block can accept them
  p_cmd_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NONE) |-> (st == ST_READY || (st == ST_SEWAIT && cmd == CMD_SECT)));

  // R4: reads during an erase carry a zero polling bit
  p_erase_b7_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && (st == ST_ERASE || st == ST_SEWAIT)) |-> (rdata[7] == 1'b0));

endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PG = 40;
  localparam int ER = 200;
  localparam int SE = 16;
  localparam int PE = 3200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_status_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 29) ^ 8'hC3;
  endfunction

  function automatic logic [7:0] pstat(logic d7, logic t);
    return {~d7, t, 6'b0};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_init();
    for (int i = 0; i < 64; i++) mdl[i] = pat(i);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_init();
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    v = rdata;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog_cmd(input logic [5:0] a, input logic [7:0] d);
    wr(6'h2A, 8'hAA); wr(6'h15, 8'h55); wr(6'h2A, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    wr(6'h2A, 8'hAA); wr(6'h15, 8'h55); wr(6'h2A, 8'h80);
    wr(6'h2A, 8'hAA); wr(6'h15, 8'h55);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [5:0] a;
    logic [7:0] d;
    void'($urandom(32'h5EED));
    model_init();
    idle(3);
    rst_n = 1'b1;

    // R1: reset contents
    rd(6'd0, v);  chk("R1 init word 0", v, pat(0));
    rd(6'd63, v); chk("R1 init word 63", v, pat(63));

    // R12: no read data without output enable
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = 6'd5;
    @(negedge clk); chk("R12 idle bus", rdata, 8'h00);
    ce_n = 1'b1;

    // R2 R3 R5: random programs into unprotected sectors
    for (int k = 0; k < 16; k++) begin
      a = 6'($urandom % 48);
      d = 8'($urandom) & mdl[a];
      prog_cmd(a, d);
      rd(a, v); chk("R3 busy poll first", v, pstat(d[7], 1'b1));
      rd(6'($urandom), v); chk("R5 busy toggle second", v, pstat(d[7], 1'b0));
      idle(PG);
      mdl[a] = mdl[a] & d;
      rd(a, v); chk("R2 programmed word", v, mdl[a]);
      rd(a, v); chk("R5 no toggle after done", v, mdl[a]);
      a = 6'($urandom);
      rd(a, v); chk("R2 random read", v, mdl[a]);
    end

    // R6: program into protected sector 3, exact length
    prog_cmd(6'd50, 8'h00);
    rd(6'd50, v); chk("R6 prot busy 1", v, 8'hC0);
    rd(6'd50, v); chk("R6 prot busy 2", v, 8'h80);
    rd(6'd50, v); chk("R6 prot unchanged", v, mdl[50]);

    // R11: broken sequence then a data write
    wr(6'h2A, 8'hAA); wr(6'h15, 8'h55); wr(6'h2A, 8'h77); wr(6'd9, 8'h00);
    rd(6'd9, v); chk("R11 no program", v, mdl[9]);

    // R4: chip erase
    erase_pre(); wr(6'h2A, 8'h10);
    rd(6'd0, v); chk("R4 erase busy 1", v, 8'h40);
    rd(6'd60, v); chk("R4 erase busy 2", v, 8'h00);
    idle(ER + 10);
    for (int i = 0; i < 64; i++) if (i < 48) mdl[i] = 8'hFF;
    for (int i = 0; i < 64; i += 7) begin
      rd(6'(i), v); chk("R4 after chip erase", v, mdl[i]);
    end

    // R7: sector erase with a second sector added in the window
    prog_cmd(6'd3, 8'h12);  idle(PG + 4); mdl[3] = 8'h12;
    prog_cmd(6'd20, 8'h34); idle(PG + 4); mdl[20] = 8'h34;
    prog_cmd(6'd40, 8'h56); idle(PG + 4); mdl[40] = 8'h56;
    erase_pre(); wr(6'd5, 8'h30);
    rd(6'd20, v); chk("R7 window status", v, 8'h40);
    wr(6'h21, 8'h30);
    rd(6'd3, v); chk("R7 window toggle", v, 8'h00);
    idle(SE + ER + 20);
    for (int i = 0; i < 16; i++) mdl[i] = 8'hFF;
    for (int i = 32; i < 48; i++) mdl[i] = 8'hFF;
    rd(6'd3, v);  chk("R7 sector0 erased", v, 8'hFF);
    rd(6'd20, v); chk("R7 sector1 kept", v, 8'h34);
    rd(6'd40, v); chk("R7 sector2 erased", v, 8'hFF);

    // R8: erase of protected sector only
    erase_pre(); wr(6'h33, 8'h30);
    rd(6'd48, v); chk("R8 busy 1", v, 8'h40);
    rd(6'd48, v); chk("R8 busy 2", v, 8'h00);
    idle(1600);
    rd(6'd48, v); chk("R8 still busy", v, 8'h40);
    idle(1700);
    rd(6'd48, v); chk("R8 unchanged", v, mdl[48]);

    // R9: program asking 0 to 1 fails and locks
    prog_cmd(6'd10, 8'h00); idle(PG + 4); mdl[10] = 8'h00;
    prog_cmd(6'd10, 8'h81);
    rd(6'd10, v); chk("R9 busy poll", v, 8'h40);
    idle(PG + 5);
    rd(6'd10, v); chk("R9 fail flag", v, 8'h20);
    prog_cmd(6'd11, 8'h00);
    rd(6'd11, v); chk("R9 writes ignored", v, 8'h60);

    // R10: reset leaves failure
    do_reset();
    rd(6'd10, v); chk("R10 reset clears fail", v, pat(10));

    // R10: reset in the middle of an erase
    erase_pre(); wr(6'h2A, 8'h10);
    rd(6'd7, v); chk("R10 erase running", v, 8'h40);
    do_reset();
    rd(6'd7, v); chk("R10 aborted erase", v, pat(7));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule